// File: doc/BRIEF.md
# Timer and Event Counter with Pulse-Width Capture

This block is a 16-bit up-counter for a microcontroller subsystem. One byte-wide control register selects its mode. In timer mode it advances on prescaled ticks of an internal clock, and that clock is either the system clock or a slow tick input. In event mode it advances on a chosen edge of an external pin. In pulse-width mode it times how long the pin stays at an active level.

Software sets a start value through a preload register. The counter runs up to all ones, reloads from the preload value on the next increment, and raises a sticky interrupt flag that software clears.

Pulse-width mode makes one measurement per enable. A start edge opens the measurement and the opposite edge closes it. When it closes, the hardware drops the run bit and leaves the result in the counter until software enables the block again.

Top module: `tmr_pwc_unit`

## Requirements
- R1: After reset the control readback is 8'h00, the count is 0 and the interrupt flag is 0.
- R2: The control byte is laid out as follows, and a write reads back unchanged:
  - bits [7:6] are the mode: 00 is off, 01 is event, 10 is timer and 11 is pulse-width.
  - bit 5 is the edge select.
  - bit 4 is the run bit.
  - bit 3 is the clock source.
  - bits [2:0] are the prescale code.
- R3: A preload write while the run bit is 0 also loads the count. While the run bit is 1, a preload write changes only the reload value and the count keeps stepping.
- R4: In timer mode with the run bit set, the count rises by one every 2^k internal clock ticks, where k is the prescale code. The first increment comes on the 2^k-th tick after the enabling write.
- R5: Clock source 0 uses every system clock cycle as an internal tick. Clock source 1 uses each cycle in which slow_tick is high.
- R6: In every mode, an increment from all ones loads the preload value and sets the interrupt flag.
- R7: The pin passes through two synchronizer flops. In event mode, edge select 0 counts rising edges of the pin and edge select 1 counts falling edges.
- R8: Pulse-width mode starts on an edge and stops on the opposite edge; a level present at enable starts nothing.
  - With edge select 1, a rising edge starts the measurement and the next falling edge stops it.
  - With edge select 0, a falling edge starts it and the next rising edge stops it.
  - With prescale code 0 and clock source 0, a pulse of L cycles adds exactly L to the count.
- R9: When a pulse-width measurement ends, the hardware clears the run bit and the count holds, even if further pulses arrive on the pin.
- R10: The interrupt flag stays set until irq_clr is high for a cycle. If an overflow and irq_clr fall in the same cycle, the flag ends up set.
- R11: With mode 00 or with the run bit at 0, the count does not change except through a preload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register readback |
| preload_wr | input | 1 | Preload register write strobe |
| preload_wdata | input | 16 | Preload write data |
| count_val | output | 16 | Current counter value |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| irq_flag | output | 1 | Overflow interrupt request flag |
| ext_pin | input | 1 | Asynchronous external input |
| slow_tick | input | 1 | One-cycle pulses of the slow reference tick |

## Verification
Several internal faults reach the ports on a predictable schedule:

- A prescaler that does not clear while the counter is stopped moves the first timer increment away from the 2^k-th tick. That shows as a count that is off by one within the first prescale period.
- A synchronizer or edge detector with the wrong depth or polarity shows up after the next pin transition. Event totals are then wrong by one edge, and pulse widths are wrong by a cycle or more.
- A measurement flag that fails to stop keeps the count growing on later pulses. A run bit that does not drop shows in the control readback a few cycles after the closing edge.
- A wrong reload or flag priority shows at the very next overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PSC_SEL_W = 3;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    // packed MSB first: mode[7:6] edge[5] run[4] src[3] psc[2:0]
    typedef struct packed {
        tmr_mode_e            mode;
        logic                 edge_sel;
        logic                 run;
        logic                 src_slow;
        logic [PSC_SEL_W-1:0] psc;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o =  st_q.sync[MSB] & ~st_q.prev;
    assign fall_o = ~st_q.sync[MSB] &  st_q.prev;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = tmr_pkg::PSC_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             base_tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } psc_st_t;

    psc_st_t          st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel_i));
        end
    end

    always_comb begin
        st_d = st_q;
        if (!run_i)           st_d.cnt = '0;
        else if (base_tick_i) st_d.cnt = st_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // tick on the base tick that completes a period of 2^sel
    assign tick_o = run_i & base_tick_i & (&(st_q.cnt | ~mask));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  tmr_ctrl_t        ctrl_wdata_i,
    input  logic             preload_wr_i,
    input  logic [CNT_W-1:0] preload_wdata_i,
    input  logic             irq_clr_i,
    input  logic             ptick_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             psc_run_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] preload;
        logic [CNT_W-1:0] count;
        logic             pw_active;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     inc, pw_done, ovf;
    logic     start_e, stop_e, ev_e;

    always_comb begin
        st_d    = st_q;
        inc     = 1'b0;
        pw_done = 1'b0;
        start_e = st_q.ctrl.edge_sel ? rise_i : fall_i;
        stop_e  = st_q.ctrl.edge_sel ? fall_i : rise_i;
        ev_e    = st_q.ctrl.edge_sel ? fall_i : rise_i;

        if (st_q.ctrl.run) begin
            case (st_q.ctrl.mode)
                MODE_TIMER: inc = ptick_i;
                MODE_EVENT: inc = ev_e;
                MODE_PULSE: begin
                    if (st_q.pw_active) begin
                        inc     = ptick_i;
                        pw_done = stop_e;
                    end else if (start_e) begin
                        st_d.pw_active = 1'b1;
                    end
                end
                default: inc = 1'b0;
            endcase
        end

        if (pw_done) begin
            st_d.pw_active = 1'b0;
            st_d.ctrl.run  = 1'b0;
        end

        ovf = inc && (st_q.count == CNT_MAX);
        if (inc) st_d.count = ovf ? st_q.preload : st_q.count + CNT_W'(1);

        if (preload_wr_i) begin
            st_d.preload = preload_wdata_i;
            if (!st_q.ctrl.run) st_d.count = preload_wdata_i;
        end

        // a software write overrides the hardware clear of run
        if (ctrl_wr_i) begin
            st_d.ctrl      = ctrl_wdata_i;
            st_d.pw_active = 1'b0;
        end

        if (irq_clr_i) st_d.irq = 1'b0;
        if (ovf)       st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o    = st_q.ctrl;
    assign count_o   = st_q.count;
    assign irq_o     = st_q.irq;
    assign psc_run_o = st_q.ctrl.run &&
                       ((st_q.ctrl.mode == MODE_TIMER) ||
                        ((st_q.ctrl.mode == MODE_PULSE) && st_q.pw_active));

endmodule

// File: rtl/tmr_pwc_unit.sv
module tmr_pwc_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_rdata,
    input  logic             preload_wr,
    input  logic [CNT_W-1:0] preload_wdata,
    output logic [CNT_W-1:0] count_val,
    input  logic             irq_clr,
    output logic             irq_flag,
    input  logic             ext_pin,
    input  logic             slow_tick
);
    tmr_ctrl_t ctrl;
    logic      rise, fall, ptick, psc_run, base_tick;

    assign base_tick  = ctrl.src_slow ? slow_tick : 1'b1;
    assign ctrl_rdata = ctrl;

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (rise),
        .fall_o (fall)
    );

    tmr_prescaler #(.SEL_W(PSC_SEL_W)) psc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (psc_run),
        .base_tick_i (base_tick),
        .sel_i       (ctrl.psc),
        .tick_o      (ptick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) core_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_wr_i       (ctrl_wr),
        .ctrl_wdata_i    (tmr_ctrl_t'(ctrl_wdata)),
        .preload_wr_i    (preload_wr),
        .preload_wdata_i (preload_wdata),
        .irq_clr_i       (irq_clr),
        .ptick_i         (ptick),
        .rise_i          (rise),
        .fall_i          (fall),
        .ctrl_o          (ctrl),
        .count_o         (count_val),
        .irq_o           (irq_flag),
        .psc_run_o       (psc_run)
    );

endmodule

// File: rtl/tmr_pwc_chk.sv
module tmr_pwc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             preload_wr,
    input logic             irq_clr,
    input logic [7:0]       ctrl_rdata,
    input logic [CNT_W-1:0] count_val,
    input logic             irq_flag
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctrl_rdata[4] || ctrl_rdata[7:6] == 2'b00) && !preload_wr)
        |=> $stable(count_val));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_flag_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(irq_clr));

    p_flag_from_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(count_val) == ALL1));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_wr |=> ((count_val == $past(count_val)) ||
                         (count_val == CNT_W'($past(count_val) + CNT_W'(1))) ||
                         ($past(count_val) == ALL1)));

    p_run_drop_pw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_rdata[4]) && !$past(ctrl_wr)) |-> (ctrl_rdata[7:6] == 2'b11));

endmodule

bind tmr_pwc_unit tmr_pwc_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .preload_wr (preload_wr),
    .irq_clr    (irq_clr),
    .ctrl_rdata (ctrl_rdata),
    .count_val  (count_val),
    .irq_flag   (irq_flag)
);

// File: tb/tmr_pwc_unit_tb_top.sv
module tmr_pwc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        preload_wr = 1'b0;
    logic [15:0] preload_wdata = '0;
    logic [15:0] count_val;
    logic        irq_clr = 1'b0;
    logic        irq_flag;
    logic        ext_pin = 1'b0;
    logic        slow_tick = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tmr_pwc_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .preload_wr(preload_wr), .preload_wdata(preload_wdata),
        .count_val(count_val), .irq_clr(irq_clr), .irq_flag(irq_flag),
        .ext_pin(ext_pin), .slow_tick(slow_tick)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_preload(input logic [15:0] d);
        @(negedge clk); preload_wr = 1'b1; preload_wdata = d;
        @(negedge clk); preload_wr = 1'b0;
    endtask

    task automatic pin_pulse(input logic lvl, input int len);
        @(negedge clk); ext_pin = lvl;
        repeat (len) @(negedge clk);
        ext_pin = ~lvl;
    endtask

    task automatic clear_flag();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "ctrl", {8'h0, ctrl_rdata}, 16'h0);
        check("R1", "count", count_val, 16'h0);
        check("R1", "flag", {15'h0, irq_flag}, 16'h0);
    endtask

    task automatic t_timer_wrap();
        logic [15:0] held;
        wr_preload(16'hFFF0);
        check("R3", "stopped preload loads count", count_val, 16'hFFF0);
        wr_ctrl(8'h90);
        check("R2", "ctrl readback", {8'h0, ctrl_rdata}, 16'h0090);
        idle(5);
        check("R4", "timer div1 after 5", count_val, 16'hFFF5);
        idle(10);
        check("R4", "timer at max", count_val, 16'hFFFF);
        check("R6", "flag before wrap", {15'h0, irq_flag}, 16'h0);
        idle(1);
        check("R6", "reload on wrap", count_val, 16'hFFF0);
        check("R6", "flag after wrap", {15'h0, irq_flag}, 16'h1);
        wr_ctrl(8'h80);
        held = count_val;
        idle(10);
        check("R11", "run=0 holds", count_val, held);
        idle(3);
        check("R10", "flag sticky", {15'h0, irq_flag}, 16'h1);
        clear_flag();
        check("R10", "flag cleared", {15'h0, irq_flag}, 16'h0);
    endtask

    task automatic t_prescale();
        wr_preload(16'h0);
        wr_ctrl(8'h93);
        idle(7);
        check("R4", "div8 before 8th tick", count_val, 16'h0);
        idle(1);
        check("R4", "div8 at 8th tick", count_val, 16'h1);
        idle(32);
        check("R4", "div8 after 40", count_val, 16'h5);
        wr_ctrl(8'h00);
    endtask

    task automatic t_slow_src();
        wr_preload(16'h0);
        wr_ctrl(8'h99);
        idle(10);
        check("R5", "no slow ticks", count_val, 16'h0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
            idle(3);
        end
        check("R5", "six slow ticks div2", count_val, 16'h3);
        wr_ctrl(8'h00);
    endtask

    task automatic t_mode_off();
        wr_preload(16'h0055);
        wr_ctrl(8'h10);
        idle(5);
        pin_pulse(1'b1, 3);
        idle(10);
        check("R11", "mode 00 holds", count_val, 16'h0055);
        wr_ctrl(8'h00);
    endtask

    task automatic t_event(input logic edge_sel, input logic [15:0] exp);
        ext_pin = 1'b0;
        idle(6);
        wr_preload(16'd10);
        wr_ctrl(edge_sel ? 8'h70 : 8'h50);
        for (int i = 0; i < 3; i++) begin
            pin_pulse(1'b1, 3);
            idle(3);
        end
        @(negedge clk); ext_pin = 1'b1;
        idle(6);
        check("R7", edge_sel ? "falling edges" : "rising edges", count_val, exp);
        wr_ctrl(8'h00);
        ext_pin = 1'b0;
        idle(6);
    endtask

    task automatic t_pw_high();
        wr_preload(16'd100);
        wr_ctrl(8'hF0);
        idle(5);
        pin_pulse(1'b1, 20);
        idle(8);
        check("R8", "high pulse of 20", count_val, 16'd120);
        check("R9", "run cleared", {8'h0, ctrl_rdata}, 16'h00E0);
        pin_pulse(1'b1, 5);
        idle(8);
        check("R9", "result held", count_val, 16'd120);
    endtask

    task automatic t_pw_level();
        ext_pin = 1'b1;
        idle(6);
        wr_preload(16'h0200);
        wr_ctrl(8'hF0);
        idle(12);
        check("R8", "level at enable ignored", count_val, 16'h0200);
        @(negedge clk); ext_pin = 1'b0;
        idle(6);
        check("R8", "fall not a start", count_val, 16'h0200);
        pin_pulse(1'b1, 9);
        idle(8);
        check("R8", "high pulse of 9", count_val, 16'h0209);
    endtask

    task automatic t_pw_low();
        ext_pin = 1'b1;
        idle(6);
        wr_preload(16'h0300);
        wr_ctrl(8'hD0);
        idle(4);
        pin_pulse(1'b0, 7);
        idle(8);
        check("R8", "low pulse of 7", count_val, 16'h0307);
        check("R9", "run cleared low", {8'h0, ctrl_rdata}, 16'h00C0);
        ext_pin = 1'b0;
        idle(6);
    endtask

    task automatic t_pw_wrap();
        clear_flag();
        wr_preload(16'hFFFA);
        wr_ctrl(8'hF0);
        idle(4);
        pin_pulse(1'b1, 10);
        idle(8);
        check("R6", "pw wrap count", count_val, 16'hFFFE);
        check("R6", "pw wrap flag", {15'h0, irq_flag}, 16'h1);
        clear_flag();
        check("R10", "cleared after pw", {15'h0, irq_flag}, 16'h0);
    endtask

    task automatic t_set_wins();
        wr_preload(16'hFFFE);
        wr_ctrl(8'h90);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R10", "set beats clear", {15'h0, irq_flag}, 16'h1);
        check("R6", "reload value", count_val, 16'hFFFE);
        wr_ctrl(8'h00);
        clear_flag();
    endtask

    task automatic t_preload_running();
        wr_preload(16'h0);
        wr_ctrl(8'h90);
        idle(4);
        check("R4", "running count", count_val, 16'h4);
        wr_preload(16'h8000);
        check("R3", "running preload ignored by count", count_val, 16'h6);
        wr_ctrl(8'h00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_timer_wrap();
        t_prescale();
        t_slow_src();
        t_mode_off();
        t_event(1'b0, 16'd14);
        t_event(1'b1, 16'd13);
        t_pw_high();
        t_pw_level();
        t_pw_low();
        t_pw_wrap();
        t_set_wins();
        t_preload_running();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule